// File: doc/BRIEF.md
# Latched Prioritized Interrupt Aggregator

This block gathers the error and peripheral event lines of a controller card. Each line gets a sticky status bit. The bits are merged into seven-level processor interrupt requests. Every source has a small latch cell that records a rising edge of the source line. The record stays until software writes a one to that source's bit at a status address. Related sources share one priority level:
- the two signalling-processor interrupts (master frame and slave frame) request level 5;
- the four power-supply and battery indications request level 1;
- the interface-card presence event, a general peripheral event and the hardware clock error request level 4;
- the watchdog expiry requests level 7, which no mask can block.

The output is a 3-bit code of the highest pending, enabled level, with 0 meaning no request. Software reaches status, clear and mask through an 8-bit register bus with address, read strobe and write strobe. A separate 4-bit output carries the critical local events to the mate copy of the card, so that the pair can change over when one copy fails.

Each latch cell is a three-state machine:
- **REARM**: the source must be seen low before a new event counts. This is the state after reset and after a clear while the source is still high.
- **ARMED**: the cell waits for the source to be high.
- **PEND**: the event is held.

The transitions are:
- rearm_to_armed: source low.
- armed_to_pend: source high.
- pend_to_armed: clear with the source low.
- pend_to_rearm: clear with the source high.

Top module: `irq_aggr`

## Requirements
- R1: After reset all status bits read 0, all sources are enabled in the mask, `irq_lvl_o`, `rdata_o` and `mate_o` are 0. A status bit sets on the clock edge where its source is high after having been sampled low since reset or the last clear, so a source held high through reset is not recorded. A read strobe loads `rdata_o` on that edge with the register at `addr_i`: address 0 holds pending bits of sources 0..7 in bits 0..7; address 1 holds sources 8..9 in bits 0..1, upper bits 0.
- R2: A pending bit stays set until a write strobe to its status address (0 or 1, same bit layout as R1) carries a 1 in its bit position. Writing 0 to a bit leaves it unchanged.
- R3: If the source is still high when its bit is cleared, no new event is recorded until the source has been low and then high again.
- R4: Sources 0 and 1 (signalling-processor interrupt of master frame and of slave frame) request level 5.
- R5: Sources 2..5 (supply error copy 0, supply error copy 1, battery low copy 0, battery low copy 1) request level 1.
- R6: Sources 6 (interface-card presence), 7 (peripheral event) and 9 (hardware clock error) request level 4.
- R7: Source 8 (watchdog expiry) requests level 7 whether or not its mask bit is set.
- R8: `irq_lvl_o` is the highest level among pending, enabled sources, or 0 if there is none. It follows the status bits in the same cycle.
- R9: Mask bits sit at address 2 (sources 0..7 in bits 0..7) and address 3 (sources 8..9 in bits 0..1). A bit of 1 enables the source and reads back as written. Clearing a mask bit removes the request but keeps the pending bit, and setting it again restores the request.
- R10: `mate_o` bit 0 is the watchdog source, bit 1 the hardware clock error source, bit 2 `act_pass_i` and bit 3 `man_rst_i`, each registered one clock after its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 10 | Event source lines, synchronous, bit meanings as in R4..R7 |
| act_pass_i | input | 1 | Active-to-passive transition of this copy |
| man_rst_i | input | 1 | Manual reset of this copy |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_lvl_o | output | 3 | Encoded request level, 0 = none |
| mate_o | output | 4 | Critical events forwarded to the mate card |

## Verification
The checker watches the following on every cycle:
- no status bit appears without a high source on the previous edge;
- no pending bit drops without a matching clear write;
- a pending watchdog always yields level 7;
- an empty status yields level 0;
- the mate output follows its inputs one clock later.

The level mapping of each group, the priority among several groups, the masking that keeps the latch, and the re-arm rule after a clear of a still-high source can only be shown by the bench's scenarios. Those scenarios are compared against a behavioural model on every clock.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

    typedef enum logic [1:0] {
        LT_REARM = 2'd0,
        LT_ARMED = 2'd1,
        LT_PEND  = 2'd2
    } latch_st_t;

    localparam int LVL_W  = 3;
    localparam int BYTE_W = 8;

endpackage

// File: rtl/irq_latch_cell.sv
module irq_latch_cell
    import irq_aggr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic clr_i,
    output logic pend_o
);

    latch_st_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LT_REARM;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LT_REARM: if (!src_i) st_d = LT_ARMED;
            LT_ARMED: if (src_i)  st_d = LT_PEND;
            LT_PEND:  if (clr_i)  st_d = src_i ? LT_REARM : LT_ARMED;
            default:              st_d = LT_REARM;
        endcase
    end

    assign pend_o = (st_q == LT_PEND);

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_aggr_pkg::*;
#(
    parameter int                       N_SRC    = 10,
    parameter logic [N_SRC*LVL_W-1:0]   LVL_MAP  = '0,
    parameter logic [N_SRC-1:0]         NMI_MASK = '0
) (
    input  logic [N_SRC-1:0] pend_i,
    input  logic [N_SRC-1:0] en_i,
    output logic [LVL_W-1:0] lvl_o
);

    always_comb begin
        lvl_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend_i[i] && (en_i[i] || NMI_MASK[i]) &&
                (LVL_MAP[i*LVL_W +: LVL_W] > lvl_o))
                lvl_o = LVL_MAP[i*LVL_W +: LVL_W];
        end
    end

endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
    import irq_aggr_pkg::*;
#(
    parameter int N_SRC  = 10,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [N_SRC-1:0]  pend_i,
    output logic [N_SRC-1:0]  clr_o,
    output logic [N_SRC-1:0]  en_o,
    output logic [BYTE_W-1:0] rdata_o
);

    localparam int NB = (N_SRC + BYTE_W - 1) / BYTE_W;

    logic [N_SRC-1:0]  mask_q;
    logic [BYTE_W-1:0] rd_mux;

    always_comb begin
        for (int i = 0; i < N_SRC; i++)
            clr_o[i] = wr_en_i && (addr_i == ADDR_W'(i / BYTE_W)) &&
                       wdata_i[i % BYTE_W];
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (addr_i == ADDR_W'(i / BYTE_W))
                rd_mux[i % BYTE_W] = pend_i[i];
            if (addr_i == ADDR_W'(NB + i / BYTE_W))
                rd_mux[i % BYTE_W] = mask_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '1;
            rdata_o <= '0;
        end else begin
            if (rd_en_i) rdata_o <= rd_mux;
            for (int i = 0; i < N_SRC; i++) begin
                if (wr_en_i && (addr_i == ADDR_W'(NB + i / BYTE_W)))
                    mask_q[i] <= wdata_i[i % BYTE_W];
            end
        end
    end

    assign en_o = mask_q;

endmodule

// File: rtl/irq_aggr.sv
module irq_aggr
    import irq_aggr_pkg::*;
#(
    parameter int                     N_SRC     = 10,
    parameter int                     ADDR_W    = 2,
    parameter int                     WDOG_IDX  = 8,
    parameter int                     HWERR_IDX = 9,
    parameter logic [N_SRC*3-1:0]     LVL_MAP   = {3'd4, 3'd7, 3'd4, 3'd4,
                                                   3'd1, 3'd1, 3'd1, 3'd1,
                                                   3'd5, 3'd5},
    parameter logic [N_SRC-1:0]       NMI_MASK  = N_SRC'(1) << WDOG_IDX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              act_pass_i,
    input  logic              man_rst_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic [2:0]        irq_lvl_o,
    output logic [3:0]        mate_o
);

    logic [N_SRC-1:0] pend_w;
    logic [N_SRC-1:0] clr_w;
    logic [N_SRC-1:0] en_w;

    for (genvar g = 0; g < N_SRC; g++) begin : g_cell
        irq_latch_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_i[g]),
            .clr_i  (clr_w[g]),
            .pend_o (pend_w[g])
        );
    end

    irq_regbank #(
        .N_SRC  (N_SRC),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en_i (rd_en_i),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .pend_i  (pend_w),
        .clr_o   (clr_w),
        .en_o    (en_w),
        .rdata_o (rdata_o)
    );

    irq_prio_enc #(
        .N_SRC    (N_SRC),
        .LVL_MAP  (LVL_MAP),
        .NMI_MASK (NMI_MASK)
    ) u_enc (
        .pend_i (pend_w),
        .en_i   (en_w),
        .lvl_o  (irq_lvl_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mate_o <= '0;
        else        mate_o <= {man_rst_i, act_pass_i, src_i[HWERR_IDX], src_i[WDOG_IDX]};
    end

endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk #(
    parameter int N_SRC     = 10,
    parameter int ADDR_W    = 2,
    parameter int WDOG_IDX  = 8,
    parameter int HWERR_IDX = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  src_i,
    input logic              act_pass_i,
    input logic              man_rst_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [7:0]        wdata_i,
    input logic [N_SRC-1:0]  pend,
    input logic [2:0]        irq_lvl_o,
    input logic [3:0]        mate_o
);

    logic [N_SRC-1:0] wr_clr;

    always_comb begin
        wr_clr = '0;
        if (wr_en_i) begin
            for (int i = 0; i < N_SRC; i++)
                if (int'(addr_i) == i / 8) wr_clr[i] = wdata_i[i % 8];
        end
    end

    // R1
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~$past(pend) & ~$past(src_i)) == '0);

    // R2
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend) & ~$past(wr_clr) & ~pend) == '0);

    // R7
    wdog_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend[WDOG_IDX] |-> (irq_lvl_o == 3'd7));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (irq_lvl_o == 3'd0));

    // R10
    mate_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (mate_o == $past({man_rst_i, act_pass_i, src_i[HWERR_IDX], src_i[WDOG_IDX]})));

endmodule

bind irq_aggr irq_aggr_chk #(
    .N_SRC     (N_SRC),
    .ADDR_W    (ADDR_W),
    .WDOG_IDX  (WDOG_IDX),
    .HWERR_IDX (HWERR_IDX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_i),
    .act_pass_i (act_pass_i),
    .man_rst_i  (man_rst_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .pend       (pend_w),
    .irq_lvl_o  (irq_lvl_o),
    .mate_o     (mate_o)
);

// File: tb/sim_irq_aggr.sv
`timescale 1ns/1ps
module sim_irq_aggr;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] src = '0;
    logic       act_pass = 1'b0, man_rst = 1'b0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] irq_lvl;
    logic [3:0] mate;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    bit [9:0] m_pend, m_arm, m_mask;
    bit [7:0] m_rdata;
    bit [3:0] m_mate;

    always #2.5 clk = ~clk;

    irq_aggr u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .act_pass_i(act_pass),
        .man_rst_i(man_rst), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .irq_lvl_o(irq_lvl), .mate_o(mate)
    );

    function automatic int src_level(int i);
        if (i < 2)  return 5;
        if (i < 6)  return 1;
        if (i == 8) return 7;
        return 4;
    endfunction

    function automatic int m_level();
        int best = 0;
        for (int i = 0; i < 10; i++)
            if (m_pend[i] && (m_mask[i] || i == 8) && src_level(i) > best)
                best = src_level(i);
        return best;
    endfunction

    task automatic model_reset();
        m_pend = '0; m_arm = '0; m_mask = '1; m_rdata = '0; m_mate = '0;
    endtask

    task automatic model_edge();
        bit [9:0] cv = '0;
        if (rd_en) begin
            case (addr)
                2'd0: m_rdata = m_pend[7:0];
                2'd1: m_rdata = {6'b0, m_pend[9:8]};
                2'd2: m_rdata = m_mask[7:0];
                default: m_rdata = {6'b0, m_mask[9:8]};
            endcase
        end
        if (wr_en && addr == 2'd0) cv[7:0] = wdata;
        if (wr_en && addr == 2'd1) cv[9:8] = wdata[1:0];
        for (int i = 0; i < 10; i++) begin
            if (m_pend[i]) begin
                if (cv[i]) begin
                    m_pend[i] = 1'b0;
                    m_arm[i]  = !src[i];
                end
            end else if (m_arm[i] && src[i]) begin
                m_pend[i] = 1'b1;
                m_arm[i]  = 1'b0;
            end else begin
                m_arm[i] = !src[i];
            end
        end
        if (wr_en && addr == 2'd2) m_mask[7:0] = wdata;
        if (wr_en && addr == 2'd3) m_mask[9:8] = wdata[1:0];
        m_mate = {man_rst, act_pass, src[9], src[8]};
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1 model_edge();
        @(negedge clk);
        chk("R1 rdata vs model", rdata, m_rdata);
        chk("R8 irq_lvl vs model", irq_lvl, m_level());
        chk("R10 mate_o vs model", mate, m_mate);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic reg_wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(logic [1:0] a);
        rd_en = 1'b1; addr = a;
        step();
        rd_en = 1'b0;
    endtask

    task automatic pulse(int i);
        src[i] = 1'b1;
        step();
        src[i] = 1'b0;
        step();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1 reset irq_lvl", irq_lvl, 0);
        chk("R1 reset rdata", rdata, 0);
        chk("R1 reset mate_o", mate, 0);
        step();

        // R4 master signalling source
        src[0] = 1'b1; step();
        chk("R4 level of source 0", irq_lvl, 5);
        src[0] = 1'b0; step();
        reg_rd(2'd0);
        chk("R1 status read", rdata, 8'h01);

        // R8 priority between level 5 and level 1
        src[2] = 1'b1; step();
        chk("R8 highest of 5 and 1", irq_lvl, 5);

        // R2 zero write has no effect
        reg_wr(2'd0, 8'h00);
        chk("R2 zero write keeps level", irq_lvl, 5);
        reg_rd(2'd0);
        chk("R2 zero write keeps status", rdata, 8'h05);
        reg_wr(2'd0, 8'h01);
        chk("R5 level of source 2", irq_lvl, 1);

        // R3 clear while source still high
        reg_wr(2'd0, 8'h04);
        chk("R3 cleared while high", irq_lvl, 0);
        repeat (3) step();
        chk("R3 no recapture while high", irq_lvl, 0);
        src[2] = 1'b0; step();
        src[2] = 1'b1; step();
        chk("R3 recapture after low-high", irq_lvl, 1);
        src[2] = 1'b0;
        reg_wr(2'd0, 8'h04);
        chk("R3 cleared", irq_lvl, 0);

        // R6 / R9 presence event and masking
        pulse(6);
        chk("R6 level of source 6", irq_lvl, 4);
        reg_wr(2'd2, 8'hBF);
        chk("R9 masked removes request", irq_lvl, 0);
        reg_rd(2'd0);
        chk("R9 masked bit still latched", rdata, 8'h40);
        reg_rd(2'd2);
        chk("R9 mask readback", rdata, 8'hBF);
        reg_wr(2'd2, 8'hFF);
        chk("R9 unmask restores request", irq_lvl, 4);
        reg_wr(2'd0, 8'h40);

        // R10 / R6 hardware clock error
        src[9] = 1'b1; step();
        chk("R10 mate hw error bit", mate, 4'b0010);
        src[9] = 1'b0; step();
        chk("R6 level of source 9", irq_lvl, 4);
        reg_wr(2'd1, 8'h02);
        chk("R2 clear high byte", irq_lvl, 0);

        // R7 watchdog with all high-byte masks off
        reg_wr(2'd3, 8'h00);
        src[8] = 1'b1; step();
        chk("R10 mate watchdog bit", mate, 4'b0001);
        chk("R7 watchdog level despite mask", irq_lvl, 7);
        src[8] = 1'b0; step();
        reg_rd(2'd1);
        chk("R7 watchdog status bit", rdata, 8'h01);
        reg_rd(2'd3);
        chk("R9 high mask readback", rdata, 8'h00);
        reg_wr(2'd1, 8'h01);
        chk("R7 watchdog cleared", irq_lvl, 0);
        reg_wr(2'd3, 8'h03);

        // R8 several groups at once
        src[1] = 1'b1; src[4] = 1'b1; src[7] = 1'b1; step();
        src = '0; step();
        chk("R8 three groups pending", irq_lvl, 5);
        reg_wr(2'd0, 8'h02);
        chk("R8 after clearing level 5", irq_lvl, 4);
        reg_wr(2'd0, 8'h80);
        chk("R8 after clearing level 4", irq_lvl, 1);
        reg_wr(2'd0, 8'h10);
        chk("R8 all cleared", irq_lvl, 0);

        // R10 switchover events
        act_pass = 1'b1; man_rst = 1'b1; step();
        chk("R10 mate switchover bits", mate, 4'b1100);
        act_pass = 1'b0; man_rst = 1'b0; step();
        chk("R10 mate idle", mate, 4'b0000);

        // R1 source held high through reset is not recorded
        src[3] = 1'b1;
        do_reset();
        step();
        chk("R1 high through reset ignored", irq_lvl, 0);
        src[3] = 1'b0; step();
        src[3] = 1'b1; step();
        chk("R5 level of source 3", irq_lvl, 1);
        src[3] = 1'b0; step();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule